// File: doc/BRIEF.md
# Event State Buffer with Pending/Queued Bits

This block keeps a two-bit event state for each of a set of interrupt sources. Bit P says a notification has been sent and not yet acknowledged. Bit Q says at least one further event arrived while P was set. Software controls the state only through memory-mapped accesses, and every access names a source. The direction of the access (load or store), the page it targets (event-control page or fire page) and the offset inside that page select the operation. No data value is involved.

A store to the fire page triggers the source. When the shared-page option is on, a non-EOI store to the control page also triggers it. A trigger either sends a one-cycle notify pulse toward the router or records a coalesced event in Q. Loads return the previous state and, at some offsets, replace it. This is how masking, unmasking and end-of-interrupt are done. An EOI load that returns Q set tells software it must fire the source again.

Sources that advertise store-EOI get a store offset that re-fires the source automatically. Level-sensitive sources ignore trigger stores. For them, the level input acts as the trigger, and a load-EOI re-raises the notification if the line is still asserted.

Top module: `esb_pq`

## Requirements
- R1: After reset, every source is in state 01 (masked), and rsp_valid_o and notify_o are low.
- R2: Every load produces rsp_valid_o high for exactly one cycle, one cycle after the request. rsp_pq_o then holds the source's state before the load, with P on bit 1 and Q on bit 0. A load to the fire page, or to a control-page offset other than 0x000, 0xC00 or 0xD00, leaves the state unchanged.
- R3: A control-page load at offset 0xC00 returns the old state and sets it to 00.
- R4: A control-page load at offset 0xD00 returns the old state and sets it to 01. In state 01 a trigger changes nothing and raises no notify.
- R5: On a source that is not level-sensitive, a trigger moves the state as follows: 00 goes to 10 with a notify pulse, 10 goes to 11, and 11 stays 11. The last two raise no notify.
- R6: With SHARED_TRIG=1, a control-page store at any offset other than 0x400 triggers the source, exactly like a fire-page store.
- R7: A control-page store at offset 0x400 on a source whose store-EOI flag is set moves the state to 00. If the old Q was 1, it instead moves the state to 10 and raises a notify.
- R8: A store at offset 0x400 on a source without the store-EOI flag is treated as the ordinary control-page store of R6.
- R9: On a level-sensitive source, trigger stores are ignored. While no request addresses the source and its state is 00, a high level_i moves the state to 10 and raises a notify. On a source that is not level-sensitive, a load at offset 0x000 behaves like a load at 0xC00.
- R10: On a level-sensitive source, a load at offset 0x000 returns the old state and clears P. If level_i is high and Q is 0, P is set again and a notify is raised.
- R11: notify_o has one bit per source. It pulses for a single cycle, one cycle after the event that causes it, and P is set whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_trig_page_i | input | 1 | 1 = fire page, 0 = event-control page |
| req_off_i | input | 12 | Offset within the page |
| req_src_i | input | SRC_W | Addressed source |
| src_lsi_i | input | NUM_SRC | Per-source level-sensitive flag |
| src_st_eoi_i | input | NUM_SRC | Per-source store-EOI support flag |
| level_i | input | NUM_SRC | Per-source level line (level-sensitive sources only) |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_pq_o | output | 2 | Previous state of the loaded source, {P,Q} |
| notify_o | output | NUM_SRC | Per-source notification pulse |

## Verification
A request presented before a rising edge updates the state at that edge. Its load response and any notify it causes appear in the register outputs straight after that edge. A level change takes effect the same way, one edge after it is seen. The bench applies each stimulus at a falling edge. At the following rising edge it queues the expected response and notify vector, and a monitor compares them at the next falling edge, so every result is checked exactly one cycle after its cause. The state itself is checked only through later inspection loads, whose returned value is due on the same one-cycle schedule.

// File: rtl/esb_pkg.sv
package esb_pkg;
  localparam int OFF_W = 12;

  localparam logic [OFF_W-1:0] OFF_LD_EOI = 12'h000;
  localparam logic [OFF_W-1:0] OFF_ST_EOI = 12'h400;
  localparam logic [OFF_W-1:0] OFF_SET00  = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_SET01  = 12'hD00;

  localparam logic [1:0] PQ_RESET = 2'b01;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_ST400,
    OP_LD000,
    OP_LDC00,
    OP_LDD00,
    OP_PEEK
  } esb_op_e;
endpackage

// File: rtl/esb_decode.sv
module esb_decode
  import esb_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter bit SHARED_TRIG = 1'b1,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             req_trig_page_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [SRC_W-1:0] req_src_i,
  output esb_op_e          op_o,
  output logic [NUM_SRC-1:0] sel_o
);
  always_comb begin
    op_o = OP_NONE;
    if (req_valid_i) begin
      if (req_write_i) begin
        if (req_trig_page_i)              op_o = OP_TRIG;
        else if (req_off_i == OFF_ST_EOI) op_o = OP_ST400;
        else if (SHARED_TRIG)             op_o = OP_TRIG;
      end else if (req_trig_page_i) begin
        op_o = OP_PEEK;
      end else begin
        case (req_off_i)
          OFF_LD_EOI: op_o = OP_LD000;
          OFF_SET00:  op_o = OP_LDC00;
          OFF_SET01:  op_o = OP_LDD00;
          default:    op_o = OP_PEEK;
        endcase
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      sel_o[i] = req_valid_i && (req_src_i == SRC_W'(i));
  end
endmodule

// File: rtl/esb_cell.sv
module esb_cell
  import esb_pkg::*;
#(
  parameter bit SHARED_TRIG = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  esb_op_e    op_i,
  input  logic       lsi_i,
  input  logic       st_eoi_i,
  input  logic       level_i,
  output logic [1:0] pq_o,
  output logic       notify_o
);
  logic [1:0] pq_q, pq_n;
  logic       ntf_q, ntf_n;
  logic [1:0] trig_pq;
  logic       trig_ntf;

  // coalescing trigger: only 00 notifies, masked 01 holds
  always_comb begin
    trig_pq  = pq_q;
    trig_ntf = 1'b0;
    case (pq_q)
      2'b00: begin trig_pq = 2'b10; trig_ntf = 1'b1; end
      2'b10: trig_pq = 2'b11;
      default: trig_pq = pq_q;
    endcase
  end

  always_comb begin
    pq_n  = pq_q;
    ntf_n = 1'b0;
    if (sel_i) begin
      case (op_i)
        OP_TRIG: begin
          if (!lsi_i) begin pq_n = trig_pq; ntf_n = trig_ntf; end
        end
        OP_ST400: begin
          if (st_eoi_i) begin
            if (pq_q[0]) begin pq_n = 2'b10; ntf_n = 1'b1; end
            else           pq_n = 2'b00;
          end else if (SHARED_TRIG && !lsi_i) begin
            pq_n  = trig_pq;
            ntf_n = trig_ntf;
          end
        end
        OP_LD000: begin
          if (lsi_i) begin
            pq_n = {1'b0, pq_q[0]};
            if (level_i && !pq_q[0]) begin pq_n = 2'b10; ntf_n = 1'b1; end
          end else begin
            pq_n = 2'b00;
          end
        end
        OP_LDC00: pq_n = 2'b00;
        OP_LDD00: pq_n = 2'b01;
        default:  pq_n = pq_q;
      endcase
    end else if (lsi_i && level_i && pq_q == 2'b00) begin
      pq_n  = 2'b10;
      ntf_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_q  <= PQ_RESET;
      ntf_q <= 1'b0;
    end else begin
      pq_q  <= pq_n;
      ntf_q <= ntf_n;
    end
  end

  assign pq_o     = pq_q;
  assign notify_o = ntf_q;
endmodule

// File: rtl/esb_rsp.sv
module esb_rsp #(
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [SRC_W-1:0]         src_i,
  input  logic [NUM_SRC-1:0][1:0]  pq_all_i,
  output logic                     rsp_valid_o,
  output logic [1:0]               rsp_pq_o
);
  logic [1:0] sel_pq;

  always_comb begin
    sel_pq = 2'b00;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_i == SRC_W'(i)) sel_pq = pq_all_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pq_o    <= 2'b00;
    end else begin
      rsp_valid_o <= load_i;
      if (load_i) rsp_pq_o <= sel_pq;
    end
  end
endmodule

// File: rtl/esb_pq.sv
module esb_pq
  import esb_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter bit SHARED_TRIG = 1'b1,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic               req_trig_page_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic [SRC_W-1:0]   req_src_i,
  input  logic [NUM_SRC-1:0] src_lsi_i,
  input  logic [NUM_SRC-1:0] src_st_eoi_i,
  input  logic [NUM_SRC-1:0] level_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_pq_o,
  output logic [NUM_SRC-1:0] notify_o
);
  esb_op_e                   op;
  logic [NUM_SRC-1:0]        sel;
  logic [NUM_SRC-1:0][1:0]   pq_all;

  esb_decode #(.NUM_SRC(NUM_SRC), .SHARED_TRIG(SHARED_TRIG)) u_decode (
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_trig_page_i(req_trig_page_i),
    .req_off_i      (req_off_i),
    .req_src_i      (req_src_i),
    .op_o           (op),
    .sel_o          (sel)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    esb_cell #(.SHARED_TRIG(SHARED_TRIG)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel[g]),
      .op_i    (op),
      .lsi_i   (src_lsi_i[g]),
      .st_eoi_i(src_st_eoi_i[g]),
      .level_i (level_i[g]),
      .pq_o    (pq_all[g]),
      .notify_o(notify_o[g])
    );
  end

  esb_rsp #(.NUM_SRC(NUM_SRC)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (req_valid_i && !req_write_i),
    .src_i      (req_src_i),
    .pq_all_i   (pq_all),
    .rsp_valid_o(rsp_valid_o),
    .rsp_pq_o   (rsp_pq_o)
  );
endmodule

// File: rtl/esb_pq_chk.sv
module esb_pq_chk #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_write_i,
  input logic                    req_trig_page_i,
  input logic [11:0]             req_off_i,
  input logic [SRC_W-1:0]        req_src_i,
  input logic [NUM_SRC-1:0]      src_lsi_i,
  input logic                    rsp_valid_o,
  input logic [1:0]              rsp_pq_o,
  input logic [NUM_SRC-1:0]      notify_o,
  input logic [NUM_SRC-1:0][1:0] pq_all_i
);
  logic [1:0] addr_pq;
  logic       is_load;

  assign is_load = req_valid_i && !req_write_i;

  always_comb begin
    addr_pq = 2'b00;
    for (int i = 0; i < NUM_SRC; i++)
      if (req_src_i == SRC_W'(i)) addr_pq = pq_all_i[i];
  end

  p_rsp_follows_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load |=> rsp_valid_o);
  p_rsp_only_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(is_load));
  p_rsp_old_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load |=> rsp_pq_o == $past(addr_pq));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    p_unmask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_load && !req_trig_page_i && req_off_i == 12'hC00 && req_src_i == SRC_W'(g))
      |=> pq_all_i[g] == 2'b00);
    p_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_load && !req_trig_page_i && req_off_i == 12'hD00 && req_src_i == SRC_W'(g))
      |=> pq_all_i[g] == 2'b01);
    p_notify_pset_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      notify_o[g] |-> pq_all_i[g][1]);
    p_edge_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_lsi_i[g] && !(req_valid_i && req_write_i && req_src_i == SRC_W'(g)))
      |=> !notify_o[g]);
  end
endmodule

bind esb_pq esb_pq_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_write_i    (req_write_i),
  .req_trig_page_i(req_trig_page_i),
  .req_off_i      (req_off_i),
  .req_src_i      (req_src_i),
  .src_lsi_i      (src_lsi_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_pq_o       (rsp_pq_o),
  .notify_o       (notify_o),
  .pq_all_i       (pq_all)
);

// File: tb/esb_pq_bench.sv
module esb_pq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        req_trig_page_i = 1'b0;
  logic [11:0] req_off_i = '0;
  logic [1:0]  req_src_i = '0;
  logic [3:0]  src_lsi_i = 4'b0100;
  logic [3:0]  src_st_eoi_i = 4'b0010;
  logic [3:0]  level_i = '0;
  logic        rsp_valid_o;
  logic [1:0]  rsp_pq_o;
  logic [3:0]  notify_o;

  logic [3:0]  lvl = '0;
  int checks = 0;
  int fails = 0;
  bit         q_rv[$];
  logic [1:0] q_pq[$];
  logic [3:0] q_nt[$];
  string      q_tag[$];

  always #2 clk_i = ~clk_i;

  esb_pq u_esb_pq (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_trig_page_i, .req_off_i,
    .req_src_i, .src_lsi_i, .src_st_eoi_i, .level_i, .rsp_valid_o, .rsp_pq_o,
    .notify_o
  );

  task automatic step(input bit v, input bit w, input bit tp, input logic [11:0] off,
                      input logic [1:0] src, input bit erv, input logic [1:0] epq,
                      input logic [3:0] ent, input string tag);
    @(negedge clk_i);
    req_valid_i = v; req_write_i = w; req_trig_page_i = tp;
    req_off_i = off; req_src_i = src; level_i = lvl;
    @(posedge clk_i);
    q_rv.push_back(erv); q_pq.push_back(epq); q_nt.push_back(ent); q_tag.push_back(tag);
  endtask

  task automatic ld(input logic [1:0] src, input bit tp, input logic [11:0] off,
                    input logic [1:0] epq, input logic [3:0] ent, input string tag);
    step(1'b1, 1'b0, tp, off, src, 1'b1, epq, ent, tag);
  endtask

  task automatic st(input logic [1:0] src, input bit tp, input logic [11:0] off,
                    input logic [3:0] ent, input string tag);
    step(1'b1, 1'b1, tp, off, src, 1'b0, 2'b00, ent, tag);
  endtask

  task automatic idle(input logic [3:0] ent, input string tag);
    step(1'b0, 1'b0, 1'b0, 12'h000, 2'd0, 1'b0, 2'b00, ent, tag);
  endtask

  // monitor: compares results one cycle after their stimulus
  always @(negedge clk_i) begin
    while (q_rv.size() > 0) begin
      automatic bit         erv = q_rv.pop_front();
      automatic logic [1:0] epq = q_pq.pop_front();
      automatic logic [3:0] ent = q_nt.pop_front();
      automatic string      tag = q_tag.pop_front();
      checks++;
      if (rsp_valid_o !== erv) begin
        fails++;
        $display("FAIL %s rsp_valid act=%0b exp=%0b", tag, rsp_valid_o, erv);
      end
      if (erv) begin
        checks++;
        if (rsp_pq_o !== epq) begin
          fails++;
          $display("FAIL %s rsp_pq act=%b exp=%b", tag, rsp_pq_o, epq);
        end
      end
      checks++;
      if (notify_o !== ent) begin
        fails++;
        $display("FAIL %s notify act=%b exp=%b", tag, notify_o, ent);
      end
    end
  end

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (rsp_valid_o !== 1'b0 || notify_o !== 4'b0) begin
      fails++;
      $display("FAIL R1 reset outputs act=%b/%b exp=0/0000", rsp_valid_o, notify_o);
    end
    rst_ni = 1'b1;

    // edge source 0: reset masked, unmask, coalescing
    ld(2'd0, 1'b0, 12'hC00, 2'b01, 4'b0000, "R1 R3 unmask from reset");
    st(2'd0, 1'b1, 12'h000, 4'b0001, "R5 00->10 notify");
    st(2'd0, 1'b1, 12'h000, 4'b0000, "R5 R11 10->11 quiet");
    st(2'd0, 1'b1, 12'h000, 4'b0000, "R5 11 stays");
    ld(2'd0, 1'b1, 12'h000, 2'b11, 4'b0000, "R2 fire page peek");
    ld(2'd0, 1'b0, 12'h0F0, 2'b11, 4'b0000, "R2 other offset peek");
    ld(2'd0, 1'b0, 12'hC00, 2'b11, 4'b0000, "R3 eoi returns Q");
    ld(2'd0, 1'b0, 12'h0F0, 2'b00, 4'b0000, "R3 state 00");
    ld(2'd0, 1'b0, 12'hD00, 2'b00, 4'b0000, "R4 mask");
    st(2'd0, 1'b1, 12'h000, 4'b0000, "R4 masked trigger quiet");
    ld(2'd0, 1'b0, 12'h0F0, 2'b01, 4'b0000, "R4 stays 01");
    // source 3: load at 0x000 acts as unmask, shared page trigger
    ld(2'd3, 1'b0, 12'h000, 2'b01, 4'b0000, "R9 edge load 000");
    st(2'd3, 1'b0, 12'h100, 4'b1000, "R6 shared page trigger");
    ld(2'd3, 1'b0, 12'h0F0, 2'b10, 4'b0000, "R6 state 10");
    // source 1: store-EOI
    ld(2'd1, 1'b0, 12'hC00, 2'b01, 4'b0000, "R3 unmask s1");
    st(2'd1, 1'b1, 12'h000, 4'b0010, "R5 s1 fire");
    st(2'd1, 1'b1, 12'h000, 4'b0000, "R5 s1 coalesce");
    st(2'd1, 1'b0, 12'h400, 4'b0010, "R7 store eoi refire");
    ld(2'd1, 1'b0, 12'h0F0, 2'b10, 4'b0000, "R7 state 10");
    st(2'd1, 1'b0, 12'h400, 4'b0000, "R7 store eoi no Q");
    ld(2'd1, 1'b0, 12'h0F0, 2'b00, 4'b0000, "R7 state 00");
    // source 0: 0x400 store without store-EOI support
    ld(2'd0, 1'b0, 12'hC00, 2'b01, 4'b0000, "R3 unmask s0");
    st(2'd0, 1'b0, 12'h400, 4'b0001, "R8 400 as trigger");
    ld(2'd0, 1'b0, 12'h0F0, 2'b10, 4'b0000, "R8 state 10");
    // source 2: level-sensitive
    ld(2'd2, 1'b0, 12'hC00, 2'b01, 4'b0000, "R3 unmask s2");
    st(2'd2, 1'b1, 12'h000, 4'b0000, "R9 lsi fire ignored");
    st(2'd2, 1'b0, 12'h100, 4'b0000, "R9 lsi shared ignored");
    ld(2'd2, 1'b0, 12'h0F0, 2'b00, 4'b0000, "R9 lsi still 00");
    lvl = 4'b0100;
    idle(4'b0100, "R9 level notify");
    idle(4'b0000, "R11 single pulse");
    ld(2'd2, 1'b0, 12'h000, 2'b10, 4'b0100, "R10 load eoi level high");
    lvl = 4'b0000;
    ld(2'd2, 1'b0, 12'h000, 2'b10, 4'b0000, "R10 load eoi level low");
    ld(2'd2, 1'b0, 12'h0F0, 2'b00, 4'b0000, "R10 P cleared");
    ld(2'd2, 1'b0, 12'hD00, 2'b00, 4'b0000, "R4 mask s2");
    lvl = 4'b0100;
    idle(4'b0000, "R4 masked level quiet");
    ld(2'd2, 1'b0, 12'h000, 2'b01, 4'b0000, "R10 masked load eoi");
    ld(2'd2, 1'b0, 12'h0F0, 2'b01, 4'b0000, "R10 stays masked");
    lvl = 4'b0000;
    idle(4'b0000, "R11 idle");
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule